// File: doc/BRIEF.md
# Over-Integration Pixel Readout Sequencer

This block is the digital control for a pulse-frequency-modulated pixel that improves its resolution through over-integration. A frame is divided into a fixed number of integration sub-periods. In each one, a small saturating counter counts the comparator pulses. When the integration window of a sub-period closes, the count is written into a word register and shifted out serially, and the counter starts again from zero. The integration-capacitor reset is not pulsed at that point. It stays low for the whole frame, so the leftover charge from each sub-period carries into the next one. The downstream decimation filter uses this to obtain first-order shaping of the quantization error.

The frame length in clock cycles is a parameter. It equals the clock frequency divided by the frame rate (for example 100 Hz). The sub-period length is the frame length divided by the over-integration ratio (64 by default, 128 also supported). The last few cycles of each sub-period can be set aside as a hold gap. During the gap no pulses are counted, which gives the serial readout time to finish. A strobe marks the final word of each frame so that the decimator can align its frames.

Top module: `ovi_readout_seq`

## Requirements
- R1: While `rst` is high, and on the following cycles until a frame starts, `cap_rst` is 1 and `dw_strobe`, `shift_en`, `ser_out`, `frame_valid` and `ovf_flag` are 0.
- R2: When `frame_start` is seen high while idle (`cap_rst` = 1), `cap_rst` drops on the next cycle. The frame then lasts SUBS sub-periods of SUB_CYC = FRAME_CYC/SUBS cycles each. `cap_rst` stays 0 throughout and returns to 1 in the cycle after the last cycle of the last sub-period.
- R3: `pulse_in` is asynchronous and passes through a two-flop synchronizer. Each rising edge (high and low for at least two clocks each) adds one to the count if it is detected within the first INT_CYC = SUB_CYC − HOLD_CYC cycles of a sub-period.
- R4: `dw_strobe` is high for exactly one cycle, the cycle at offset INT_CYC within each sub-period. That strobe stores the count, and each sub-period's count starts again from zero.
- R5: Edges detected in the hold gap (offsets INT_CYC..SUB_CYC−1) or while idle are not counted in any word.
- R6: The count saturates at 2^CNT_W − 1 (31). A counted edge that arrives while the count is already at that value sets `ovf_flag`. The flag stays set until the next accepted `frame_start` or reset.
- R7: On the cycle after `dw_strobe`, `shift_en` goes high for CNT_W cycles. `ser_out` carries the stored word MSB first during those cycles and is 0 otherwise. Shifting ends before the next `dw_strobe`.
- R8: `frame_valid` is high together with the `dw_strobe` of the last sub-period of a frame, and at no other time.
- R9: `frame_start` is ignored while a frame is running. The frame timing, the words and `ovf_flag` are unaffected.
- R10: A reset in the middle of a frame returns the block to idle: `cap_rst` is 1 and no further `dw_strobe` occurs until a new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a frame when seen while idle |
| pulse_in | input | 1 | Asynchronous comparator pulse train |
| cap_rst | output | 1 | Integration-capacitor reset, high while idle |
| dw_strobe | output | 1 | One-cycle strobe that stores the sub-period count |
| shift_en | output | 1 | High while serial data is valid |
| ser_out | output | 1 | Serial count, MSB first |
| frame_valid | output | 1 | Marks the final word of a frame |
| ovf_flag | output | 1 | Sticky count saturation flag for the current frame |

## Verification
The bench drives exact pulse counts in each sub-period and reads back every serial word. A counter that is not cleared between sub-periods would show running totals, and a reversed shift order would show bit-mirrored words. Pulses are placed inside the hold gap and before the frame starts. A design that counted them would report inflated words. One sub-period receives 40 pulses, and a stray `frame_start` arrives in the middle of that frame. A design without saturation would wrap to 8, and one that honoured the stray start would restart the timing or clear the flag early. `cap_rst` is sampled in every cycle of the frame, so a reset pulse between sub-periods would be caught. A reset in the middle of a frame, followed by a quiet window, exposes any strobe that keeps running after the reset.

// File: rtl/ovi_pkg.sv
package ovi_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_st_e;

    // Per-cycle control produced by the sub-period timer
    typedef struct packed {
        logic cnt_en;     // inside the integration window
        logic restart;    // store word, restart counter
        logic frame_clr;  // frame accepted this cycle
        logic last_word;  // stored word is the last of the frame
    } seq_ctl_t;

    function automatic logic at_full(input logic [15:0] value, input int unsigned width);
        return value == ((16'd1 << width) - 16'd1);
    endfunction

endpackage

// File: rtl/ovi_pulse_sync.sv
module ovi_pulse_sync (
    input  logic clk,
    input  logic rst,
    input  logic pulse_async,
    output logic rise_det
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], pulse_async};
    end

    assign rise_det = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/ovi_sub_timer.sv
module ovi_sub_timer
    import ovi_pkg::*;
#(
    parameter int unsigned SUBS     = 64,
    parameter int unsigned SUB_CYC  = 48,
    parameter int unsigned HOLD_CYC = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_start,
    output seq_ctl_t ctl,
    output logic     cap_rst,
    output logic     dw_strobe,
    output logic     frame_valid
);
    localparam int unsigned INT_CYC = SUB_CYC - HOLD_CYC;
    localparam int unsigned TICK_W  = (SUB_CYC > 1) ? $clog2(SUB_CYC) : 1;
    localparam int unsigned SUB_W   = (SUBS > 1) ? $clog2(SUBS) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SUB_CYC - 1);
    localparam logic [TICK_W-1:0] TICK_INTL = TICK_W'(INT_CYC - 1);
    localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(SUBS - 1);

    seq_st_e           st_q;
    logic [TICK_W-1:0] tick_q;
    logic [SUB_W-1:0]  sub_q;
    logic              end_int_q, last_q;
    logic              int_close;

    assign int_close = (st_q == SEQ_RUN) && (tick_q == TICK_INTL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            tick_q <= '0;
            sub_q  <= '0;
        end else if (st_q == SEQ_IDLE) begin
            if (frame_start) begin
                st_q   <= SEQ_RUN;
                tick_q <= '0;
                sub_q  <= '0;
            end
        end else if (tick_q == TICK_LAST) begin
            tick_q <= '0;
            if (sub_q == SUB_LAST) st_q  <= SEQ_IDLE;
            else                   sub_q <= sub_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            end_int_q <= 1'b0;
            last_q    <= 1'b0;
        end else begin
            end_int_q <= int_close;
            last_q    <= int_close && (sub_q == SUB_LAST);
        end
    end

    always_comb begin
        ctl.cnt_en    = (st_q == SEQ_RUN) && (tick_q < TICK_W'(INT_CYC));
        ctl.restart   = end_int_q;
        ctl.frame_clr = (st_q == SEQ_IDLE) && frame_start;
        ctl.last_word = last_q;
    end

    assign cap_rst     = (st_q == SEQ_IDLE);
    assign dw_strobe   = end_int_q;
    assign frame_valid = last_q;
endmodule

// File: rtl/ovi_sat_counter.sv
module ovi_sat_counter
    import ovi_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_det,
    input  seq_ctl_t         ctl,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q, inc, full;

    assign inc  = rise_det & ctl.cnt_en;
    assign full = at_full(16'(cnt_q), CNT_W);

    always_ff @(posedge clk) begin
        if (rst || ctl.frame_clr) begin
            cnt_q <= '0;
        end else if (ctl.restart) begin
            cnt_q <= inc ? CNT_W'(1) : '0;
        end else if (inc && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.frame_clr)                ovf_q <= 1'b0;
        else if (inc && full && !ctl.restart)    ovf_q <= 1'b1;
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;
endmodule

// File: rtl/ovi_word_shifter.sv
module ovi_word_shifter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] word_in,
    output logic             shift_en,
    output logic             ser_out
);
    localparam int unsigned BC_W = $clog2(CNT_W + 1);

    logic [CNT_W-1:0] word_q;
    logic [BC_W-1:0]  left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            left_q <= '0;
        end else if (load) begin
            word_q <= word_in;
            left_q <= BC_W'(CNT_W);
        end else if (left_q != '0) begin
            word_q <= {word_q[CNT_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign shift_en = (left_q != '0);
    assign ser_out  = shift_en & word_q[CNT_W-1];
endmodule

// File: rtl/ovi_readout_seq.sv
module ovi_readout_seq
    import ovi_pkg::*;
#(
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned SUBS      = 64,
    parameter int unsigned FRAME_CYC = 3072,
    parameter int unsigned HOLD_CYC  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic pulse_in,
    output logic cap_rst,
    output logic dw_strobe,
    output logic shift_en,
    output logic ser_out,
    output logic frame_valid,
    output logic ovf_flag
);
    localparam int unsigned SUB_CYC = FRAME_CYC / SUBS;

    if (SUB_CYC < CNT_W + 1 || HOLD_CYC >= SUB_CYC || SUBS < 2 || CNT_W < 2 || CNT_W > 16) begin : g_bad_cfg
        $error("ovi_readout_seq: sub-period too short for readout or bad sizes");
    end

    seq_ctl_t         ctl;
    logic             rise_det;
    logic [CNT_W-1:0] count;

    ovi_pulse_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .pulse_async(pulse_in),
        .rise_det   (rise_det)
    );

    ovi_sub_timer #(
        .SUBS    (SUBS),
        .SUB_CYC (SUB_CYC),
        .HOLD_CYC(HOLD_CYC)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .ctl        (ctl),
        .cap_rst    (cap_rst),
        .dw_strobe  (dw_strobe),
        .frame_valid(frame_valid)
    );

    ovi_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .rise_det(rise_det),
        .ctl     (ctl),
        .count   (count),
        .ovf     (ovf_flag)
    );

    ovi_word_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.restart),
        .word_in (count),
        .shift_en(shift_en),
        .ser_out (ser_out)
    );
endmodule

// File: rtl/ovi_readout_chk.sv
module ovi_readout_chk (
    input logic clk,
    input logic rst,
    input logic frame_start,
    input logic cap_rst,
    input logic dw_strobe,
    input logic shift_en,
    input logic ser_out,
    input logic frame_valid,
    input logic ovf_flag
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> cap_rst && !dw_strobe && !shift_en && !frame_valid && !ovf_flag); // R1

    AST_DW_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dw_strobe |=> !dw_strobe); // R4

    AST_SHIFT_FOLLOWS_DW: assert property (@(posedge clk) disable iff (rst)
        dw_strobe |=> shift_en); // R7

    AST_SHIFT_DONE_BEFORE_DW: assert property (@(posedge clk) disable iff (rst)
        dw_strobe |-> !shift_en); // R7

    AST_SER_QUIET: assert property (@(posedge clk) disable iff (rst)
        !shift_en |-> !ser_out); // R7

    AST_FV_WITH_DW: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> dw_strobe); // R8

    AST_NO_DW_IDLE: assert property (@(posedge clk) disable iff (rst)
        cap_rst && $past(cap_rst) && !$past(rst) |-> !dw_strobe); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) && !$past(rst) |-> $past(frame_start && cap_rst)); // R6
endmodule

bind ovi_readout_seq ovi_readout_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .cap_rst    (cap_rst),
    .dw_strobe  (dw_strobe),
    .shift_en   (shift_en),
    .ser_out    (ser_out),
    .frame_valid(frame_valid),
    .ovf_flag   (ovf_flag)
);

// File: tb/ovi_readout_seq_bench.sv
module ovi_readout_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 5;
    localparam int SUBS       = 4;
    localparam int FRAME_CYC  = 800;
    localparam int HOLD_CYC   = 8;
    localparam int SUB_CYC    = FRAME_CYC / SUBS;
    localparam int INT_CYC    = SUB_CYC - HOLD_CYC;
    localparam int FULL       = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic pulse_in = 1'b0;
    logic cap_rst, dw_strobe, shift_en, ser_out, frame_valid, ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int words [0:255];
    bit fvlog [0:255];
    int widx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovi_readout_seq #(
        .CNT_W(CNT_W), .SUBS(SUBS), .FRAME_CYC(FRAME_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_ovi_readout_seq (
        .clk(clk), .rst(rst), .frame_start(frame_start), .pulse_in(pulse_in),
        .cap_rst(cap_rst), .dw_strobe(dw_strobe), .shift_en(shift_en),
        .ser_out(ser_out), .frame_valid(frame_valid), .ovf_flag(ovf_flag)
    );

    // serial word collector
    initial begin
        int acc = 0;
        int nb = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                nb = 0; acc = 0;
            end else begin
                if (dw_strobe) fvlog[widx & 255] = frame_valid;
                if (shift_en) begin
                    acc = ((acc << 1) | int'(ser_out)) & FULL;
                    nb++;
                    if (nb == CNT_W) begin
                        words[widx & 255] = acc;
                        widx++;
                        nb = 0; acc = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cap_rst == 1'b1, "R1 cap_rst in reset", cap_rst, 1);
        chk({dw_strobe, shift_en, ser_out, frame_valid, ovf_flag} == 5'b0,
            "R1 outputs low in reset", {dw_strobe, shift_en, ser_out, frame_valid, ovf_flag}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(cap_rst == 1'b1, "R1 idle after reset", cap_rst, 1);
        chk(dw_strobe == 1'b0 && shift_en == 1'b0, "R1 no strobe when idle", dw_strobe, 0);
    endtask

    // pulses while idle, ending well before the frame start
    task automatic idle_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pulse_in = 1'b1; repeat (2) @(negedge clk);
            pulse_in = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    // Runs one full frame; counts[s] pulses in the integration window of sub-period s
    task automatic run_frame(input int counts [SUBS], input bit gap, input bit mid_start,
                             input bit exp_ovf, input string tag);
        int base = widx;
        int timing_bad = 0;
        int cap_bad = 0;
        int ovf_seen_mid = 0;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk(cap_rst == 1'b0, {"R2 cap_rst drops ", tag}, cap_rst, 0);
        chk(ovf_flag == 1'b0, {"R6 flag cleared at frame start ", tag}, ovf_flag, 0);
        for (int s = 0; s < SUBS; s++) begin
            for (int c = 0; c < SUB_CYC; c++) begin
                bit p = 1'b0;
                if (c < 4 * counts[s]) p = (c % 4) < 2;
                if (gap && c >= INT_CYC && c < INT_CYC + 6) p = ((c - INT_CYC) % 4) < 2;
                pulse_in = p;
                frame_start = mid_start && s == 1 && c == 50;
                if (dw_strobe != (c == INT_CYC)) timing_bad++;
                if (cap_rst != 1'b0) cap_bad++;
                if (mid_start && s == SUBS - 1 && c == 0 && ovf_flag) ovf_seen_mid = 1;
                @(negedge clk);
            end
        end
        pulse_in = 1'b0;
        frame_start = 1'b0;
        chk(timing_bad == 0, {"R4 R11 strobe offset ", tag}, timing_bad, 0);
        chk(cap_bad == 0, {"R2 cap_rst low whole frame ", tag}, cap_bad, 0);
        chk(cap_rst == 1'b1, {"R2 cap_rst after last sub-period ", tag}, cap_rst, 1);
        chk(ovf_flag == exp_ovf, {"R6 flag at frame end ", tag}, ovf_flag, int'(exp_ovf));
        if (mid_start) chk(ovf_seen_mid == 1, "R9 flag kept across stray start", ovf_seen_mid, 1);
        chk(widx - base == SUBS, {"R7 words per frame ", tag}, widx - base, SUBS);
        for (int s = 0; s < SUBS; s++) begin
            int exp = (counts[s] > FULL) ? FULL : counts[s];
            chk(words[(base + s) & 255] == exp, {"R3 R5 R6 R7 word value ", tag},
                words[(base + s) & 255], exp);
            chk(fvlog[(base + s) & 255] == (s == SUBS - 1), {"R8 frame_valid ", tag},
                int'(fvlog[(base + s) & 255]), int'(s == SUBS - 1));
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic t_basic();
        int cnts [SUBS] = '{3, 0, 17, 31};
        run_frame(cnts, 1'b0, 1'b0, 1'b0, "basic");
    endtask

    task automatic t_gap_idle();
        int cnts [SUBS] = '{5, 9, 1, 12};
        idle_pulses(6);
        run_frame(cnts, 1'b1, 1'b0, 1'b0, "gap/idle R5");
    endtask

    task automatic t_saturate();
        int cnts [SUBS] = '{40, 2, 31, 0};
        run_frame(cnts, 1'b0, 1'b1, 1'b1, "saturate R9");
    endtask

    task automatic t_clear();
        int cnts [SUBS] = '{1, 6, 2, 8};
        run_frame(cnts, 1'b0, 1'b0, 1'b0, "after overflow");
    endtask

    task automatic t_mid_reset();
        int dw_after = 0;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int c = 0; c < 300; c++) begin
            pulse_in = (c % 4) < 2;
            @(negedge clk);
        end
        pulse_in = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cap_rst == 1'b1, "R10 cap_rst after mid-frame reset", cap_rst, 1);
        chk(ovf_flag == 1'b0, "R10 flag cleared by reset", ovf_flag, 0);
        for (int c = 0; c < 2 * SUB_CYC; c++) begin
            if (dw_strobe || shift_en) dw_after++;
            @(negedge clk);
        end
        chk(dw_after == 0, "R10 no strobe after reset", dw_after, 0);
    endtask

    initial begin
        do_reset();
        t_basic();
        t_gap_idle();
        t_saturate();
        t_clear();
        t_mid_reset();
        t_basic();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule